// File: doc/BRIEF.md
# Low-Power to High-Speed Entry Detector

This block watches the low-power line pair of a serial camera/display clock lane and of its first data lane, and decides when each lane has made a legal move from low-power signalling into high-speed transmission. Only then does it switch on that lane's high-speed receiver termination. Each lane is checked by its own state machine. The clock-lane machine runs on a free-running oscillator clock, and the data-lane machine runs on a free-running byte clock. A settle timer in the byte domain then raises a qualifier. Downstream logic uses this qualifier to decide when deserialised bytes may be trusted.

A legal entry is a stop state (both lines high, LP11), then a request state (LP01), then a bridge state (LP00). Before a line state counts, it must hold for `STABLE_CYC` consecutive samples. This rejects glitches on the slow single-ended receivers. When a lane goes back to LP11, its termination drops and the machine re-arms for the next burst. When the clock lane runs continuously, a mode input keeps its termination permanently on.

The state machines use four named states:

- `S_WAIT_STOP`: waiting for a stop state.
- `S_STOP_SEEN`: a stop state was accepted.
- `S_REQ_SEEN`: a request was accepted.
- `S_HS_ON`: the lane is in high speed and its termination is on.

They use these transitions:

- `S_WAIT_STOP` to `S_STOP_SEEN` when LP11 is accepted.
- `S_STOP_SEEN` to `S_REQ_SEEN` when LP01 is accepted.
- `S_REQ_SEEN` to `S_HS_ON` when LP00 is accepted.
- `S_HS_ON` to `S_STOP_SEEN` when LP11 is accepted (re-arm).
- `S_STOP_SEEN` or `S_REQ_SEEN` to `S_WAIT_STOP` when any other accepted state arrives (abort).
- Any state to `S_WAIT_STOP` while the lane is held. Only the clock lane is held, and only in continuous mode.

Top module: `lpdet_hs_entry`

## Requirements
- R1: While `rst_n` is low with `cont_clk_mode` low, `clk_term_en`, `dat_term_en` and `hs_settled` are all 0, and both machines wait for a stop state.
- R2: While `cont_clk_mode` is 1, `clk_term_en` is 1 in the same cycle, whatever the clock-lane line state. When the mode returns to 0, the clock lane restarts from `S_WAIT_STOP` and `clk_term_en` is 0.
- R3: With `cont_clk_mode` 0, `clk_term_en` rises only after LP11, then LP01, then LP00 have each been accepted on `clk_lane_lp`. Line pairs are encoded {P,N}: LP11=2'b11, LP01=2'b01, LP00=2'b00, LP10=2'b10. The rise comes on the (STABLE_CYC+1)-th rising `osc_clk` edge that samples LP00.
- R4: `dat_term_en` follows the same legal sequence on `dat_lane_lp`, on `byte_clk`, with the same latency counted in byte clocks.
- R5: A line state is accepted only after STABLE_CYC consecutive identical samples. A shorter pulse of LP01 does not advance a lane. A shorter pulse of LP11 during high speed does not drop its termination.
- R6: Any accepted state out of order aborts to `S_WAIT_STOP` without enabling termination. Examples are LP10 after LP11, or LP00 directly after LP11.
- R7: An accepted LP11 in high speed drops that lane's termination on the (STABLE_CYC+1)-th LP11 sample. The lane is then already re-armed, so LP01 followed by LP00 enables termination again.
- R8: `hs_settled` rises SETTLE_CYC byte clocks after `dat_term_en` rises, where SETTLE_CYC = ceil((85000 + 6·UI_PS) / (UI_PS·RX_GEAR)) (times in ps). The default values give 15.
- R9: `hs_settled` falls in the same cycle as `dat_term_en` when the data lane returns to the stop state.
- R10: Activity on one lane never changes the other lane's termination or qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_clk | input | 1 | Free-running oscillator clock for the clock-lane check |
| byte_clk | input | 1 | Free-running byte clock for the data-lane check and settle timer |
| cont_clk_mode | input | 1 | 1 = continuous clock lane, termination forced on |
| clk_lane_lp | input | 2 | Sampled clock-lane low-power pair {P,N} |
| dat_lane_lp | input | 2 | Sampled data-lane-0 low-power pair {P,N} |
| clk_term_en | output | 1 | Clock-lane high-speed termination enable |
| dat_term_en | output | 1 | Data-lane high-speed termination enable |
| hs_settled | output | 1 | Data-valid qualifier after the settle delay |

## Verification
A line state driven before the first sampling edge is accepted after STABLE_CYC edges. The state register moves on the next edge, so a termination enable changes on the (STABLE_CYC+1)-th edge. `hs_settled` follows SETTLE_CYC edges after that, and the continuous-mode override takes effect in the same cycle. The bench drives inputs on falling edges. On every rising edge it updates a behavioural model built from per-lane sample queues and a progress counter. It compares all three outputs 1 ns after that edge. Directed checks wait exactly the counted number of falling edges, and check one edge before and one edge at each due point.

// File: rtl/lpdet_pkg.sv
package lpdet_pkg;

    typedef enum logic [1:0] {
        S_WAIT_STOP = 2'd0,
        S_STOP_SEEN = 2'd1,
        S_REQ_SEEN  = 2'd2,
        S_HS_ON     = 2'd3
    } entry_state_t;

    // Line pair encoding {P,N}
    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_REQ    = 2'b01;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

    // Settle delay in byte clocks: ceil((85 ns + 6 UI) / byte period)
    function automatic int settle_cycles(input int ui_ps, input int gear);
        int byte_ps;
        byte_ps = ui_ps * gear;
        return (85000 + 6 * ui_ps + byte_ps - 1) / byte_ps;
    endfunction

endpackage

// File: rtl/lpdet_line_filter.sv
module lpdet_line_filter
    import lpdet_pkg::*;
#(
    parameter int STABLE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] raw,
    output logic [1:0] level,
    output logic       valid
);

    localparam int RUN_W = $clog2(STABLE_CYC + 1);

    logic [1:0]       cand_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= LP_STOP;
            run_q  <= '0;
        end else begin
            cand_q <= raw;
            if (raw != cand_q) begin
                run_q <= RUN_W'(1);
            end else if (run_q != RUN_W'(STABLE_CYC)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    always_comb begin
        level = cand_q;
        valid = (run_q == RUN_W'(STABLE_CYC));
    end

    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && raw == level) |=> (valid && $stable(level))); // R5

    if (STABLE_CYC > 1) begin : g_reject
        AST_FILTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (raw != level) |=> !valid); // R5
    end

endmodule

// File: rtl/lpdet_entry_fsm.sv
module lpdet_entry_fsm
    import lpdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [1:0] level,
    input  logic       valid,
    output logic       term_en
);

    entry_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WAIT_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_STOP: begin
                if (valid && level == LP_STOP) state_d = S_STOP_SEEN;
            end
            S_STOP_SEEN: begin
                if (valid) begin
                    if (level == LP_REQ)       state_d = S_REQ_SEEN;
                    else if (level != LP_STOP) state_d = S_WAIT_STOP;
                end
            end
            S_REQ_SEEN: begin
                if (valid) begin
                    if (level == LP_BRIDGE)    state_d = S_HS_ON;
                    else if (level != LP_REQ)  state_d = S_WAIT_STOP;
                end
            end
            S_HS_ON: begin
                if (valid && level == LP_STOP) state_d = S_STOP_SEEN;
            end
        endcase
        if (hold) state_d = S_WAIT_STOP;
    end

    always_comb begin
        term_en = (state_q == S_HS_ON);
    end

    AST_ENTRY_NEEDS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_en) |-> ($past(valid) && $past(level) == LP_BRIDGE)); // R4

    AST_STOP_DROPS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (term_en && valid && level == LP_STOP) |=> !term_en); // R7

    AST_REQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REQ_SEEN) |->
            ($past(state_q) == S_STOP_SEEN || $past(state_q) == S_REQ_SEEN)); // R6

    AST_ABORT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP_SEEN && valid && level != LP_STOP && level != LP_REQ)
            |=> (state_q == S_WAIT_STOP)); // R6

endmodule

// File: rtl/lpdet_settle_timer.sv
module lpdet_settle_timer #(
    parameter int SETTLE_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic term_en,
    output logic settled
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!term_en) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (cnt_q != CW'(SETTLE_CYC)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(SETTLE_CYC - 1)) done_q <= 1'b1;
        end
    end

    always_comb begin
        settled = done_q & term_en;
    end

    AST_SETTLE_NOT_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> $past(term_en)); // R8

    AST_SETTLE_DROPS_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_en) |-> !settled); // R9

endmodule

// File: rtl/lpdet_hs_entry.sv
module lpdet_hs_entry
    import lpdet_pkg::*;
#(
    parameter int STABLE_CYC = 3,
    parameter int UI_PS      = 800,
    parameter int RX_GEAR    = 8
) (
    input  logic       rst_n,
    input  logic       osc_clk,
    input  logic       byte_clk,
    input  logic       cont_clk_mode,
    input  logic [1:0] clk_lane_lp,
    input  logic [1:0] dat_lane_lp,
    output logic       clk_term_en,
    output logic       dat_term_en,
    output logic       hs_settled
);

    localparam int SETTLE_CYC = settle_cycles(UI_PS, RX_GEAR);

    logic [1:0] ck_level, dt_level;
    logic       ck_valid, dt_valid;
    logic       ck_fsm_term;

    // Clock lane, oscillator domain
    lpdet_line_filter #(.STABLE_CYC(STABLE_CYC)) u_ck_filt (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .raw   (clk_lane_lp),
        .level (ck_level),
        .valid (ck_valid)
    );

    lpdet_entry_fsm u_ck_fsm (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .hold    (cont_clk_mode),
        .level   (ck_level),
        .valid   (ck_valid),
        .term_en (ck_fsm_term)
    );

    // Data lane 0, byte domain
    lpdet_line_filter #(.STABLE_CYC(STABLE_CYC)) u_dt_filt (
        .clk   (byte_clk),
        .rst_n (rst_n),
        .raw   (dat_lane_lp),
        .level (dt_level),
        .valid (dt_valid)
    );

    lpdet_entry_fsm u_dt_fsm (
        .clk     (byte_clk),
        .rst_n   (rst_n),
        .hold    (1'b0),
        .level   (dt_level),
        .valid   (dt_valid),
        .term_en (dat_term_en)
    );

    lpdet_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (byte_clk),
        .rst_n   (rst_n),
        .term_en (dat_term_en),
        .settled (hs_settled)
    );

    always_comb begin
        clk_term_en = cont_clk_mode | ck_fsm_term;
    end

    AST_CONT_FORCES_TERM: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cont_clk_mode |-> clk_term_en); // R2

    AST_CONT_RELEASE_CLEAN: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(cont_clk_mode) |-> !clk_term_en); // R2

endmodule

// File: tb/lpdet_hs_entry_test.sv
`timescale 1ns/1ps
module lpdet_hs_entry_test;

    localparam int N    = 3;
    localparam int UI   = 800;
    localparam int GEAR = 8;
    localparam int S    = (85000 + 6 * UI + UI * GEAR - 1) / (UI * GEAR);

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cont;
    logic [1:0] cl, dl;
    logic       clk_term_en, dat_term_en, hs_settled;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    lpdet_hs_entry #(.STABLE_CYC(N), .UI_PS(UI), .RX_GEAR(GEAR)) uut (
        .rst_n         (rst_n),
        .osc_clk       (clk),
        .byte_clk      (clk),
        .cont_clk_mode (cont),
        .clk_lane_lp   (cl),
        .dat_lane_lp   (dl),
        .clk_term_en   (clk_term_en),
        .dat_term_en   (dat_term_en),
        .hs_settled    (hs_settled)
    );

    // Behavioural reference: per-lane sample history and progress 0..3
    logic [1:0] hist_c[$];
    logic [1:0] hist_d[$];
    int  prog_c, prog_d, age;

    function automatic bit steady(input logic [1:0] q[$]);
        if (q.size() != N) return 1'b0;
        foreach (q[i]) if (q[i] != q[0]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int advance(input int p, input bit ok, input logic [1:0] v);
        if (!ok) return p;
        case (p)
            0: return (v == 2'b11) ? 1 : 0;
            1: return (v == 2'b01) ? 2 : ((v == 2'b11) ? 1 : 0);
            2: return (v == 2'b00) ? 3 : ((v == 2'b01) ? 2 : 0);
            default: return (v == 2'b11) ? 1 : 3;
        endcase
    endfunction

    task automatic cmp(input bit act, input bit exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_c.delete();
            hist_d.delete();
            prog_c = 0;
            prog_d = 0;
            age    = 0;
        end else begin
            bit ok_c, ok_d, was_hs;
            ok_c   = steady(hist_c);
            ok_d   = steady(hist_d);
            was_hs = (prog_d == 3);
            prog_c = advance(prog_c, ok_c, hist_c.size() > 0 ? hist_c[hist_c.size()-1] : 2'b11);
            if (cont) prog_c = 0;
            prog_d = advance(prog_d, ok_d, hist_d.size() > 0 ? hist_d[hist_d.size()-1] : 2'b11);
            age    = was_hs ? age + 1 : 0;
            hist_c.push_back(cl);
            if (hist_c.size() > N) void'(hist_c.pop_front());
            hist_d.push_back(dl);
            if (hist_d.size() > N) void'(hist_d.pop_front());
        end
        #1;
        if (!done) begin
            cmp(clk_term_en, cont || (prog_c == 3), "R3 clk_term_en model");
            cmp(dat_term_en, prog_d == 3, "R4 dat_term_en model");
            cmp(hs_settled, (prog_d == 3) && (age >= S), "R8 hs_settled model");
        end
    end

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cont = 1'b0; cl = 2'b11; dl = 2'b11;
        wn(3);
        cmp(clk_term_en, 0, "R1 reset clk_term_en");
        cmp(dat_term_en, 0, "R1 reset dat_term_en");
        cmp(hs_settled, 0, "R1 reset hs_settled");
        rst_n = 1'b1;

        // Legal data-lane entry
        wn(N + 2);
        dl = 2'b01; wn(N + 2);
        dl = 2'b00; wn(N);
        cmp(dat_term_en, 0, "R4 one edge early");
        wn(1);
        cmp(dat_term_en, 1, "R4 entry");
        wn(S - 1);
        cmp(hs_settled, 0, "R8 one edge early");
        wn(1);
        cmp(hs_settled, 1, "R8 settled");
        cmp(clk_term_en, 0, "R10 clock lane untouched");

        // Short stop glitch during HS
        dl = 2'b11; wn(N - 1);
        dl = 2'b00; wn(N + 2);
        cmp(dat_term_en, 1, "R5 short stop ignored");
        cmp(hs_settled, 1, "R5 settled kept");

        // Return to stop
        dl = 2'b11; wn(N);
        cmp(dat_term_en, 1, "R7 before drop");
        cmp(hs_settled, 1, "R9 before drop");
        wn(1);
        cmp(dat_term_en, 0, "R7 drop on stop");
        cmp(hs_settled, 0, "R9 drop with term");

        // Re-arm
        wn(2);
        dl = 2'b01; wn(N + 2);
        dl = 2'b00; wn(N + 1);
        cmp(dat_term_en, 1, "R7 rearmed entry");
        dl = 2'b11; wn(N + 3);

        // Short request pulse
        dl = 2'b01; wn(N - 1);
        dl = 2'b00; wn(2 * N + 2);
        cmp(dat_term_en, 0, "R5 short request rejected");

        // Illegal orders
        dl = 2'b11; wn(N + 2);
        dl = 2'b10; wn(N + 2);
        dl = 2'b00; wn(N + 2);
        cmp(dat_term_en, 0, "R6 LP10 aborts");
        dl = 2'b11; wn(N + 2);
        dl = 2'b00; wn(N + 2);
        cmp(dat_term_en, 0, "R6 skipped request");

        // Clock lane, non-continuous
        cl = 2'b01; wn(N + 2);
        cl = 2'b00; wn(N);
        cmp(clk_term_en, 0, "R3 one edge early");
        wn(1);
        cmp(clk_term_en, 1, "R3 entry");
        cmp(dat_term_en, 0, "R10 data lane untouched");
        cl = 2'b11; wn(N + 1);
        cmp(clk_term_en, 0, "R7 clock lane drop");

        // Continuous mode
        cont = 1'b1; cl = 2'b00; wn(1);
        cmp(clk_term_en, 1, "R2 forced on");
        cl = 2'b10; wn(N + 2);
        cmp(clk_term_en, 1, "R2 ignores line state");
        cont = 1'b0; wn(1);
        cmp(clk_term_en, 0, "R2 release restarts");

        wn(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule